// File: doc/BRIEF.md
# SMBus Host Transaction Engine

This block is a register-mapped host controller for SMBus transactions. Software first fills in the target address, the command code, any outgoing data bytes and, for block formats, the byte count. It then writes a protocol code. That single write both selects the transaction and starts it. The engine steps through the transaction on a byte-level bus master interface. Each request on that interface is one of four operations: start (also used as a repeated start), write byte, read byte, or stop. When the whole transaction has ended, the engine clears the protocol register and loads a status byte: a done flag plus a five-bit result code.

The supported formats are quick, send byte, receive byte, write/read byte, write/read word, block write/read, process call and block process call. The engine handles the bus-level details itself. It adds the read/write bit to the address. It issues the repeated start on the combined formats. It orders word data low byte first. It checks the block length that a device returns. It ends with a coded error when the device does not acknowledge, or when the request cannot be served.

Top module: `smbus_host_engine`

## Requirements
- R1: After reset, every register reads 0 and no bus request is made. Register offsets are: 0x00 protocol, 0x01 status (read-only), 0x02 address, 0x03 command, 0x04..0x23 data buffer (buffer byte i at offset 0x04+i), 0x24 byte count. Other offsets read 0.
- R2: Writing a nonzero value to the protocol register while it reads 0 starts a transaction and clears the status register to 0. The protocol register keeps reading the written value until the transaction ends. At the end it returns to 0, and at the same moment status becomes 0x80 | code, where bit 7 is done and bits 4:0 are the result code (0x00 means success).
- R3: The first address byte sent is address-register bits 7:1 followed by the R/W bit (1 = read). On combined formats, a write phase is followed by a repeated start and the address again with bit 0 = 1.
- R4: Protocol codes, with bit 0 = 1 meaning read: 0x02/0x03 quick (address only); 0x04 send byte (transmits the command register); 0x05 receive byte; 0x06/0x07 byte data; 0x08/0x09 word data; 0x0A/0x0B block; 0x0C process call; 0x0D block process call. Every write format other than quick sends the command register right after the address.
- R5: Word data is little-endian. Buffer byte 0 is the first byte on the bus in both directions, and buffer byte 1 is the second. Receive byte and read byte place their result in buffer byte 0.
- R6: A block write sends the count register, then that many buffer bytes. A block read takes the first byte returned as the length, stores it in the count register, and then reads that many bytes into buffer 0 upward.
- R7: When reading, the host acknowledges every byte except the last data byte of the transaction, which it does not acknowledge. Bus interface encoding: op 0 = start, 1 = write, 2 = read, 3 = stop. For a read, the ack output is 1 to acknowledge.
- R8: If either address byte is not acknowledged, the engine issues stop and ends with code 0x10.
- R9: If a command, count or data byte the host writes is not acknowledged, the engine issues stop and ends with code 0x11.
- R10: If a block read returns a length of 0 or more than 32, the engine issues stop, ends with code 0x11 and leaves the count register unchanged.
- R11: An undefined protocol code, or any code with bit 7 (checksum request) set, ends with code 0x19 without any bus request.
- R12: A block write or block process call whose count register is 0 or greater than 32 ends with code 0x13 without any bus request.
- R13: While a transaction runs, writes to any register are ignored.
- R14: Process call sends the command and two buffer bytes, then does a repeated start and reads two bytes back into buffer 0 and 1. Block process call writes a counted block, then does a repeated start and reads a counted block as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational on regAddr) |
| busReq | output | 1 | One-cycle request for one byte-level bus operation |
| busOp | output | 2 | Operation: 0 start, 1 write, 2 read, 3 stop |
| busWrByte | output | 8 | Byte to transmit for a write operation |
| busAckOut | output | 1 | For a read: 1 acknowledge, 0 no acknowledge |
| busDone | input | 1 | One-cycle completion of the pending operation |
| busAckIn | input | 1 | For a write: 1 when the device acknowledged |
| busRdByte | input | 8 | Byte received by a read operation |

## Verification
The assertions assume that the bus master answers each request with exactly one busDone pulse, arriving at least one cycle after the request. They also assume that busAckIn and busRdByte are valid in the cycle of that pulse. The bench's responder always answers after a fixed delay of a few cycles and never pulses busDone on its own. Software is expected to start a new transaction only after the previous one has ended. The stimulus polls the protocol register for zero before each launch; the single exception is the deliberate write made while busy, which exercises R13.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } busOp_e;

  typedef enum logic [1:0] {
    LEN_NONE,
    LEN_ONE,
    LEN_TWO,
    LEN_BLOCK
  } len_e;

  typedef struct packed {
    logic valid;
    logic addrRd;   // R/W bit of the first address byte
    logic hasCmd;   // command byte follows the address
    len_e wr;       // write payload after command
    len_e rd;       // read payload
  } plan_t;

  typedef struct packed {
    logic       protoClr;
    logic       statusLd;
    logic [4:0] code;
    logic       cntLd;
    logic       bufLd;
  } strobe_t;

  localparam logic [4:0] RC_OK      = 5'h00;
  localparam logic [4:0] RC_NOACK   = 5'h10;
  localparam logic [4:0] RC_DEVERR  = 5'h11;
  localparam logic [4:0] RC_UNKNOWN = 5'h13;
  localparam logic [4:0] RC_NOPROTO = 5'h19;

  function automatic plan_t decodeProto(input logic [7:0] p);
    plan_t r;
    r = '{valid: 1'b1, addrRd: 1'b0, hasCmd: 1'b0, wr: LEN_NONE, rd: LEN_NONE};
    case (p)
      8'h02: ;
      8'h03: r.addrRd = 1'b1;
      8'h04: r.hasCmd = 1'b1;
      8'h05: begin r.addrRd = 1'b1; r.rd = LEN_ONE; end
      8'h06: begin r.hasCmd = 1'b1; r.wr = LEN_ONE; end
      8'h07: begin r.hasCmd = 1'b1; r.rd = LEN_ONE; end
      8'h08: begin r.hasCmd = 1'b1; r.wr = LEN_TWO; end
      8'h09: begin r.hasCmd = 1'b1; r.rd = LEN_TWO; end
      8'h0A: begin r.hasCmd = 1'b1; r.wr = LEN_BLOCK; end
      8'h0B: begin r.hasCmd = 1'b1; r.rd = LEN_BLOCK; end
      8'h0C: begin r.hasCmd = 1'b1; r.wr = LEN_TWO; r.rd = LEN_TWO; end
      8'h0D: begin r.hasCmd = 1'b1; r.wr = LEN_BLOCK; r.rd = LEN_BLOCK; end
      default: r.valid = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] lenOf(input len_e k, input logic [7:0] cnt);
    case (k)
      LEN_ONE:   return 8'd1;
      LEN_TWO:   return 8'd2;
      LEN_BLOCK: return cnt;
      default:   return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/smbh_datapath.sv
module smbh_datapath
  import smbh_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int ADDR_W    = 6,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        rxByte,
  output logic [7:0]        protoQ,
  output logic [7:0]        statusQ,
  output logic [7:0]        addrQ,
  output logic [7:0]        cmdQ,
  output logic [7:0]        countQ,
  output logic [7:0]        bufByte
);

  localparam logic [ADDR_W-1:0] OFF_PROTO  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STATUS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_ADDR   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_CMD    = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFF_BUF    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_COUNT  = ADDR_W'(4 + BUF_DEPTH);

  logic [7:0]        bufQ [BUF_DEPTH];
  logic              busy;
  logic              inBuf;
  logic [ADDR_W-1:0] bufOff;

  assign busy   = (protoQ != 8'd0);
  assign inBuf  = (regAddr >= OFF_BUF) && (regAddr < OFF_COUNT);
  assign bufOff = regAddr - OFF_BUF;
  assign bufByte = bufQ[idx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protoQ  <= '0;
      statusQ <= '0;
      addrQ   <= '0;
      cmdQ    <= '0;
      countQ  <= '0;
      for (int i = 0; i < BUF_DEPTH; i++) bufQ[i] <= '0;
    end else begin
      if (regWe && !busy) begin
        if (regAddr == OFF_PROTO) begin
          protoQ <= regWdata;
          if (regWdata != 8'd0) statusQ <= '0;
        end
        if (regAddr == OFF_ADDR)  addrQ  <= regWdata;
        if (regAddr == OFF_CMD)   cmdQ   <= regWdata;
        if (regAddr == OFF_COUNT) countQ <= regWdata;
        if (inBuf) bufQ[bufOff[IDX_W-1:0]] <= regWdata;
      end
      if (stb.protoClr) protoQ  <= '0;
      if (stb.statusLd) statusQ <= {1'b1, 2'b00, stb.code};
      if (stb.cntLd)    countQ  <= rxByte;
      if (stb.bufLd)    bufQ[idx] <= rxByte;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == OFF_PROTO)  regRdata = protoQ;
    if (regAddr == OFF_STATUS) regRdata = statusQ;
    if (regAddr == OFF_ADDR)   regRdata = addrQ;
    if (regAddr == OFF_CMD)    regRdata = cmdQ;
    if (regAddr == OFF_COUNT)  regRdata = countQ;
    if (inBuf)                 regRdata = bufQ[bufOff[IDX_W-1:0]];
  end

endmodule

// File: rtl/smbh_control.sv
module smbh_control
  import smbh_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       protoQ,
  input  logic [7:0]       addrQ,
  input  logic [7:0]       cmdQ,
  input  logic [7:0]       countQ,
  input  logic [7:0]       bufByte,
  input  logic             busDone,
  input  logic             busAckIn,
  input  logic [7:0]       busRdByte,
  output logic             busReq,
  output logic [1:0]       busOp,
  output logic [7:0]       busWrByte,
  output logic             busAckOut,
  output strobe_t          stb,
  output logic [IDX_W-1:0] idx,
  output logic             stepIsAddr
);

  localparam logic [7:0] MAX_LEN = 8'(BUF_DEPTH);

  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WAIT, PH_FIN} phase_e;
  typedef enum logic [3:0] {
    ST_START, ST_ADDR, ST_CMD, ST_WCNT, ST_WDATA,
    ST_RSTART, ST_ADDRR, ST_RCNT, ST_RDATA, ST_STOP
  } step_e;

  phase_e           phaseQ;
  step_e            stepQ, nxt;
  logic [IDX_W-1:0] idxQ;
  logic [4:0]       resQ;
  plan_t            plan;
  logic [7:0]       wrLen, rdLen, idxExt;
  logic             lastWr, lastRd, rxLenOk, cntOk, errHit, opDone;
  logic [4:0]       errCode;

  assign plan    = decodeProto(protoQ);
  assign wrLen   = lenOf(plan.wr, countQ);
  assign rdLen   = lenOf(plan.rd, countQ);
  assign idxExt  = 8'(idxQ);
  assign lastWr  = (idxExt + 8'd1 == wrLen);
  assign lastRd  = (idxExt + 8'd1 == rdLen);
  assign rxLenOk = (busRdByte != 8'd0) && (busRdByte <= MAX_LEN);
  assign cntOk   = (countQ != 8'd0) && (countQ <= MAX_LEN);
  assign opDone  = (phaseQ == PH_WAIT) && busDone;
  assign idx     = idxQ;
  assign stepIsAddr = (stepQ == ST_ADDR) || (stepQ == ST_ADDRR);

  // Step that follows the current one once its bus operation completes
  always_comb begin
    nxt     = stepQ;
    errHit  = 1'b0;
    errCode = RC_OK;
    case (stepQ)
      ST_START: nxt = ST_ADDR;
      ST_ADDR: begin
        if (!busAckIn) begin nxt = ST_STOP; errHit = 1'b1; errCode = RC_NOACK; end
        else if (plan.hasCmd)        nxt = ST_CMD;
        else if (plan.rd != LEN_NONE) nxt = ST_RDATA;
        else                          nxt = ST_STOP;
      end
      ST_CMD: begin
        if (!busAckIn) begin nxt = ST_STOP; errHit = 1'b1; errCode = RC_DEVERR; end
        else if (plan.wr == LEN_BLOCK) nxt = ST_WCNT;
        else if (plan.wr != LEN_NONE)  nxt = ST_WDATA;
        else if (plan.rd != LEN_NONE)  nxt = ST_RSTART;
        else                           nxt = ST_STOP;
      end
      ST_WCNT: begin
        if (!busAckIn) begin nxt = ST_STOP; errHit = 1'b1; errCode = RC_DEVERR; end
        else nxt = ST_WDATA;
      end
      ST_WDATA: begin
        if (!busAckIn) begin nxt = ST_STOP; errHit = 1'b1; errCode = RC_DEVERR; end
        else if (!lastWr)             nxt = ST_WDATA;
        else if (plan.rd != LEN_NONE) nxt = ST_RSTART;
        else                          nxt = ST_STOP;
      end
      ST_RSTART: nxt = ST_ADDRR;
      ST_ADDRR: begin
        if (!busAckIn) begin nxt = ST_STOP; errHit = 1'b1; errCode = RC_NOACK; end
        else if (plan.rd == LEN_BLOCK) nxt = ST_RCNT;
        else                           nxt = ST_RDATA;
      end
      ST_RCNT: begin
        if (!rxLenOk) begin nxt = ST_STOP; errHit = 1'b1; errCode = RC_DEVERR; end
        else nxt = ST_RDATA;
      end
      ST_RDATA: nxt = lastRd ? ST_STOP : ST_RDATA;
      default:  nxt = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      stepQ  <= ST_START;
      idxQ   <= '0;
      resQ   <= RC_OK;
    end else begin
      case (phaseQ)
        PH_IDLE: if (protoQ != 8'd0) begin
          idxQ <= '0;
          if (!plan.valid) begin
            resQ <= RC_NOPROTO; phaseQ <= PH_FIN;
          end else if (plan.wr == LEN_BLOCK && !cntOk) begin
            resQ <= RC_UNKNOWN; phaseQ <= PH_FIN;
          end else begin
            resQ <= RC_OK; stepQ <= ST_START; phaseQ <= PH_REQ;
          end
        end
        PH_REQ: phaseQ <= PH_WAIT;
        PH_WAIT: if (busDone) begin
          if (stepQ == ST_STOP) phaseQ <= PH_FIN;
          else begin
            stepQ  <= nxt;
            idxQ   <= (nxt == stepQ) ? idxQ + 1'b1 : '0;
            if (errHit) resQ <= errCode;
            phaseQ <= PH_REQ;
          end
        end
        default: phaseQ <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    busReq = (phaseQ == PH_REQ);
    case (stepQ)
      ST_START, ST_RSTART: busOp = OP_START;
      ST_STOP:             busOp = OP_STOP;
      ST_RCNT, ST_RDATA:   busOp = OP_READ;
      default:             busOp = OP_WRITE;
    endcase
    case (stepQ)
      ST_ADDR:  busWrByte = {addrQ[7:1], plan.addrRd};
      ST_ADDRR: busWrByte = {addrQ[7:1], 1'b1};
      ST_CMD:   busWrByte = cmdQ;
      ST_WCNT:  busWrByte = countQ;
      ST_WDATA: busWrByte = bufByte;
      default:  busWrByte = 8'd0;
    endcase
    busAckOut = (stepQ == ST_RDATA) ? !lastRd : 1'b1;
    stb          = '0;
    stb.protoClr = (phaseQ == PH_FIN);
    stb.statusLd = (phaseQ == PH_FIN);
    stb.code     = resQ;
    stb.cntLd    = opDone && (stepQ == ST_RCNT) && rxLenOk;
    stb.bufLd    = opDone && (stepQ == ST_RDATA);
  end

endmodule

// File: rtl/smbus_host_engine.sv
module smbus_host_engine
  import smbh_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int ADDR_W    = $clog2(BUF_DEPTH + 5)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              busReq,
  output logic [1:0]        busOp,
  output logic [7:0]        busWrByte,
  output logic              busAckOut,
  input  logic              busDone,
  input  logic              busAckIn,
  input  logic [7:0]        busRdByte
);

  localparam int IDX_W = $clog2(BUF_DEPTH);

  strobe_t          stb;
  logic [IDX_W-1:0] idx;
  logic [7:0]       protoQ, statusQ, addrQ, cmdQ, countQ, bufByte;
  logic             stepIsAddr;

  smbh_datapath #(.BUF_DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .stb(stb), .idx(idx),
    .rxByte(busRdByte), .protoQ(protoQ), .statusQ(statusQ), .addrQ(addrQ),
    .cmdQ(cmdQ), .countQ(countQ), .bufByte(bufByte)
  );

  smbh_control #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .protoQ(protoQ), .addrQ(addrQ), .cmdQ(cmdQ),
    .countQ(countQ), .bufByte(bufByte), .busDone(busDone),
    .busAckIn(busAckIn), .busRdByte(busRdByte), .busReq(busReq),
    .busOp(busOp), .busWrByte(busWrByte), .busAckOut(busAckOut),
    .stb(stb), .idx(idx), .stepIsAddr(stepIsAddr)
  );

endmodule

// File: rtl/smbh_checker.sv
module smbh_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busReq,
  input logic [1:0] busOp,
  input logic [7:0] busWrByte,
  input logic [7:0] protoQ,
  input logic [7:0] statusQ,
  input logic [7:0] addrQ,
  input logic       stepIsAddr
);

  p_req_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> !busReq);

  p_no_req_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (protoQ == 8'd0) |-> !busReq);

  p_done_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protoQ != 8'd0) |-> statusQ[7]);

  p_launch_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protoQ != 8'd0) |-> (statusQ == 8'd0));

  p_addr_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && stepIsAddr) |-> (busOp == 2'd1 && busWrByte[7:1] == addrQ[7:1]));

  p_hold_busy_r13: assert property (@(posedge clk) disable iff (!rstN)
    ($past(protoQ) != 8'd0) |-> $stable(addrQ));

endmodule

bind smbus_host_engine smbh_checker u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busOp(busOp),
  .busWrByte(busWrByte), .protoQ(protoQ), .statusQ(statusQ),
  .addrQ(addrQ), .stepIsAddr(stepIsAddr)
);

// File: tb/smbus_host_engine_test.sv
`timescale 1ns/1ps
module smbus_host_engine_test;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [7:0]    regWdata = '0;
  logic [7:0]    regRdata;
  logic          busReq, busAckOut;
  logic [1:0]    busOp;
  logic [7:0]    busWrByte;
  logic          busDone = 1'b0;
  logic          busAckIn = 1'b0;
  logic [7:0]    busRdByte = '0;

  always #2.5 clk = ~clk;

  smbus_host_engine uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busReq(busReq),
    .busOp(busOp), .busWrByte(busWrByte), .busAckOut(busAckOut),
    .busDone(busDone), .busAckIn(busAckIn), .busRdByte(busRdByte)
  );

  typedef struct {
    logic [1:0] op;
    logic [7:0] val;
    string      req;
  } ev_t;

  ev_t  expQ[$];
  int   nChk = 0;
  int   nFail = 0;
  int   nackAt = -1;
  logic [7:0] rdBytes [64];
  int   rdFill = 0;
  bit   ended = 1'b0;

  // device responder
  logic       pend = 1'b0;
  logic [1:0] lat = '0;
  logic [1:0] opL = '0;
  int         wrCnt = 0;
  int         rdPtr = 0;

  always @(posedge clk) begin
    busDone <= 1'b0;
    if (busReq) begin
      pend <= 1'b1;
      lat  <= 2'd1;
      opL  <= busOp;
    end else if (pend) begin
      if (lat == 2'd0) begin
        pend    <= 1'b0;
        busDone <= 1'b1;
        if (opL == 2'd0) wrCnt <= 0;
        if (opL == 2'd1) begin
          busAckIn <= (wrCnt != nackAt);
          wrCnt    <= wrCnt + 1;
        end
        if (opL == 2'd2) begin
          busRdByte <= rdBytes[rdPtr];
          rdPtr     <= rdPtr + 1;
        end
      end else lat <= lat - 2'd1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare every bus request against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && busReq && !ended) begin
      if (expQ.size() == 0) chk("R11", "unexpected bus op", int'(busOp), 99);
      else begin
        ev_t e;
        e = expQ.pop_front();
        chk(e.req, "bus op", int'(busOp), int'(e.op));
        if (e.op == 2'd1) chk(e.req, "bus write byte", int'(busWrByte), int'(e.val));
        if (e.op == 2'd2) chk(e.req, "read ack", int'(busAckOut), int'(e.val));
      end
    end
  end

  task automatic push(input logic [1:0] op, input logic [7:0] val, input string req);
    ev_t e;
    e.op = op; e.val = val; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic devData(input logic [7:0] b);
    rdBytes[rdFill] = b;
    rdFill++;
  endtask

  task automatic regWr(input int a, input logic [7:0] d);
    @(negedge clk);
    regAddr = AW'(a); regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRd(input int a, output logic [7:0] d);
    @(negedge clk);
    regAddr = AW'(a);
    #1 d = regRdata;
  endtask

  task automatic expReg(input int a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    regRd(a, v);
    chk(req, $sformatf("reg 0x%0h", a), int'(v), int'(exp));
  endtask

  task automatic runTx(input logic [7:0] proto, input logic [7:0] status, input string req);
    logic [7:0] v;
    bit fin;
    fin = 1'b0;
    regWr(0, proto);
    for (int i = 0; i < 4000; i++) begin
      regRd(0, v);
      if (v == 8'd0) begin fin = 1'b1; break; end
    end
    chk(req, "completion", int'(fin), 1);
    chk(req, "scoreboard drained", expQ.size(), 0);
    expReg(1, status, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busReq after reset", int'(busReq), 0);
    rstN = 1'b1;
    expReg(0, 8'h00, "R1");
    expReg(1, 8'h00, "R1");
    expReg(36, 8'h00, "R1");
    expReg(4, 8'h00, "R1");
    chk("R1", "busReq idle", int'(busReq), 0);

    regWr(2, 8'hA0);

    // R2/R3/R4/R13 quick write, with a write attempt while busy
    push(0, 0, "R4"); push(1, 8'hA0, "R3"); push(3, 0, "R4");
    regWr(0, 8'h02);
    expReg(0, 8'h02, "R2");
    regWr(2, 8'h12);
    runTx(8'h02, 8'h80, "R2");
    expReg(2, 8'hA0, "R13");

    // R3 quick read
    push(0, 0, "R4"); push(1, 8'hA1, "R3"); push(3, 0, "R4");
    runTx(8'h03, 8'h80, "R3");

    // R4 send byte transmits command register
    regWr(3, 8'h5A);
    push(0, 0, "R4"); push(1, 8'hA0, "R4"); push(1, 8'h5A, "R4"); push(3, 0, "R4");
    runTx(8'h04, 8'h80, "R4");

    // R5/R7 receive byte
    devData(8'h3C);
    push(0, 0, "R4"); push(1, 8'hA1, "R3"); push(2, 0, "R7"); push(3, 0, "R4");
    runTx(8'h05, 8'h80, "R5");
    expReg(4, 8'h3C, "R5");

    // R5 write word little-endian
    regWr(3, 8'h11); regWr(4, 8'h34); regWr(5, 8'h12);
    push(0, 0, "R4"); push(1, 8'hA0, "R3"); push(1, 8'h11, "R4");
    push(1, 8'h34, "R5"); push(1, 8'h12, "R5"); push(3, 0, "R4");
    runTx(8'h08, 8'h80, "R5");

    // R5/R3/R7 read word with repeated start
    regWr(3, 8'h22);
    devData(8'hCD); devData(8'hAB);
    push(0, 0, "R4"); push(1, 8'hA0, "R3"); push(1, 8'h22, "R4");
    push(0, 0, "R3"); push(1, 8'hA1, "R3");
    push(2, 1, "R7"); push(2, 0, "R7"); push(3, 0, "R4");
    runTx(8'h09, 8'h80, "R5");
    expReg(4, 8'hCD, "R5");
    expReg(5, 8'hAB, "R5");

    // R6 block write of 3
    regWr(3, 8'h33); regWr(36, 8'd3);
    regWr(4, 8'h01); regWr(5, 8'h02); regWr(6, 8'h03);
    push(0, 0, "R6"); push(1, 8'hA0, "R6"); push(1, 8'h33, "R6"); push(1, 8'h03, "R6");
    push(1, 8'h01, "R6"); push(1, 8'h02, "R6"); push(1, 8'h03, "R6"); push(3, 0, "R6");
    runTx(8'h0A, 8'h80, "R6");

    // R6 block read of 4
    devData(8'd4); devData(8'h09); devData(8'h08); devData(8'h07); devData(8'h06);
    push(0, 0, "R6"); push(1, 8'hA0, "R6"); push(1, 8'h33, "R6");
    push(0, 0, "R6"); push(1, 8'hA1, "R6"); push(2, 1, "R6");
    push(2, 1, "R7"); push(2, 1, "R7"); push(2, 1, "R7"); push(2, 0, "R7"); push(3, 0, "R6");
    runTx(8'h0B, 8'h80, "R6");
    expReg(36, 8'd4, "R6");
    expReg(4, 8'h09, "R6");
    expReg(7, 8'h06, "R6");

    // R14 process call
    regWr(4, 8'h55); regWr(5, 8'h66);
    devData(8'h77); devData(8'h88);
    push(0, 0, "R14"); push(1, 8'hA0, "R14"); push(1, 8'h33, "R14");
    push(1, 8'h55, "R14"); push(1, 8'h66, "R14"); push(0, 0, "R14"); push(1, 8'hA1, "R14");
    push(2, 1, "R14"); push(2, 0, "R14"); push(3, 0, "R14");
    runTx(8'h0C, 8'h80, "R14");
    expReg(4, 8'h77, "R14");
    expReg(5, 8'h88, "R14");

    // R8 address not acknowledged
    nackAt = 0;
    push(0, 0, "R8"); push(1, 8'hA0, "R8"); push(3, 0, "R8");
    runTx(8'h06, 8'h90, "R8");

    // R9 data byte not acknowledged
    nackAt = 2;
    push(0, 0, "R9"); push(1, 8'hA0, "R9"); push(1, 8'h33, "R9");
    push(1, 8'h77, "R9"); push(3, 0, "R9");
    runTx(8'h06, 8'h91, "R9");
    nackAt = -1;

    // R10 block read returns zero length
    regWr(36, 8'd5);
    devData(8'd0);
    push(0, 0, "R10"); push(1, 8'hA0, "R10"); push(1, 8'h33, "R10");
    push(0, 0, "R10"); push(1, 8'hA1, "R10"); push(2, 1, "R10"); push(3, 0, "R10");
    runTx(8'h0B, 8'h91, "R10");
    expReg(36, 8'd5, "R10");

    // R10 block read returns length above 32
    devData(8'd33);
    push(0, 0, "R10"); push(1, 8'hA0, "R10"); push(1, 8'h33, "R10");
    push(0, 0, "R10"); push(1, 8'hA1, "R10"); push(2, 1, "R10"); push(3, 0, "R10");
    runTx(8'h0B, 8'h91, "R10");
    expReg(36, 8'd5, "R10");

    // R11 undefined code and checksum request: no bus activity
    runTx(8'h0E, 8'h99, "R11");
    runTx(8'h86, 8'h99, "R11");
    runTx(8'h01, 8'h99, "R11");

    // R12 bad block write count
    regWr(36, 8'd0);
    runTx(8'h0A, 8'h93, "R12");
    regWr(36, 8'd33);
    runTx(8'h0D, 8'h93, "R12");

    // R14/R6 block process call: write 2, read 1
    regWr(36, 8'd2); regWr(4, 8'hAA); regWr(5, 8'hBB);
    devData(8'd1); devData(8'h44);
    push(0, 0, "R14"); push(1, 8'hA0, "R14"); push(1, 8'h33, "R14"); push(1, 8'h02, "R14");
    push(1, 8'hAA, "R14"); push(1, 8'hBB, "R14"); push(0, 0, "R14"); push(1, 8'hA1, "R14");
    push(2, 1, "R14"); push(2, 0, "R14"); push(3, 0, "R14");
    runTx(8'h0D, 8'h80, "R14");
    expReg(36, 8'd1, "R14");
    expReg(4, 8'h44, "R14");

    regRd(0, v);
    chk("R2", "idle at end", int'(v), 0);
    repeat (5) @(negedge clk);
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule